// File: doc/BRIEF.md
# Stall-Time Balancing Request Picker

This block chooses one pending request per cycle for a memory controller shared by several hardware threads. For each thread it counts the cycles in which that thread waits on memory while the memory is shared. It also receives an estimate of how long the same thread would have waited if it ran alone. The ratio of the two is the thread's slowdown. Among the threads that currently have at least one valid request, the largest slowdown divided by the smallest gives the unfairness figure.

While unfairness stays below a programmable threshold, the picker favours throughput. Requests that hit the open row come first, and the oldest request breaks ties. Once unfairness reaches the threshold, requests from the most slowed-down thread come ahead of everything else. Row hits and then age order the rest. Slowdown and unfairness are worked out again every cycle, so the mode follows the counters as they change. The picker itself is purely combinational from its inputs and the stall counters.

Top module: `sfair_pick`

## Requirements
- R1: Each thread's shared-stall counter adds one on every clock edge where that thread's stall input is high. It holds at all-ones instead of wrapping, and reset clears it to zero. The new value affects the outputs from the next cycle.
- R2: A thread's slowdown is its shared-stall count divided by its alone-stall estimate. An estimate of zero makes the slowdown exactly 1.0. All ratio comparisons are exact, by cross-multiplication.
- R3: Unfairness is computed only over threads that own at least one valid request. A thread without requests has no effect. When every requesting thread has a slowdown of 0, unfairness counts as 1.0.
- R4: The threshold `alpha_q8` is unsigned with 8 fractional bits, so 256 means 1.0. `fair_mode` is 1 when unfairness ≥ threshold and 0 when it is below. It is also 0 when there is no valid request.
- R5: `lag_thr` names the requesting thread with the largest slowdown. Equal slowdowns go to the lowest thread number, and the output is 0 when nothing is requested.
- R6: With `fair_mode` at 0, the choice is made in this order: a valid slot with its hit bit set, then the larger age value (larger means older), then the lower slot index.
- R7: With `fair_mode` at 1, slots whose thread equals `lag_thr` come first. After that the order is hit bit, then larger age, then lower slot index.
- R8: `pick_vld` is 1 exactly when some slot is valid, and `pick_idx` then always names a valid slot. Picks respond to request inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alpha_q8 | input | RW | Unfairness threshold, 8 fractional bits |
| stall_in | input | NT | Per-thread shared-stall indication |
| alone_in | input | NT*CW | Per-thread alone-stall estimate, thread t at bits t*CW |
| req_vld | input | NS | Slot holds a valid request |
| req_thr | input | NS*TW | Owning thread per slot |
| req_hit | input | NS | Request hits the open row |
| req_age | input | NS*AW | Request age, larger is older |
| pick_vld | output | 1 | A request is chosen |
| pick_idx | output | SW | Index of the chosen slot |
| fair_mode | output | 1 | Fairness ordering active |
| lag_thr | output | TW | Requesting thread with maximum slowdown |

## Verification
A stall counter that wrapped, failed to count, or counted the wrong thread shows up in the slowdowns it feeds. The effect is a flipped `fair_mode`, a different `lag_thr`, or a pick from another thread. It appears in the cycle after the faulty edge, provided the affected thread has a request at the time. A wrong choice of which threads take part, or a wrong threshold compare, shows within the same cycle. The bench drives ratios exactly onto the threshold and just past it to expose an off-by-one compare, holds counters at saturation to catch wrapping, and makes slowdowns equal to expose tie-breaks.

// File: rtl/sfair_pick.sv
module sfair_pick #(
  parameter int NT = 4,
  parameter int NS = 16,
  parameter int CW = 16,
  parameter int AW = 6,
  parameter int RW = 16,
  parameter int FB = 8,
  localparam int TW = $clog2(NT),
  localparam int SW = $clog2(NS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RW-1:0]    alpha_q8,
  input  logic [NT-1:0]    stall_in,
  input  logic [NT*CW-1:0] alone_in,
  input  logic [NS-1:0]    req_vld,
  input  logic [NS*TW-1:0] req_thr,
  input  logic [NS-1:0]    req_hit,
  input  logic [NS*AW-1:0] req_age,
  output logic             pick_vld,
  output logic [SW-1:0]    pick_idx,
  output logic             fair_mode,
  output logic [TW-1:0]    lag_thr
);
  localparam int PW = 2*CW + RW;
  localparam int KW = AW + 2;
  localparam logic [RW-1:0] ONE = RW'(1) << FB;

  logic [CW-1:0] sh_q [NT];
  logic [PW-1:0] num [NT];
  logic [PW-1:0] den [NT];
  logic [NT-1:0] has;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [CW-1:0] al;
    assign al = alone_in[t*CW +: CW];

    always_ff @(posedge clk) begin
      if (!rst_n)
        sh_q[t] <= '0;
      else if (stall_in[t] && sh_q[t] != '1)
        sh_q[t] <= sh_q[t] + 1'b1;
    end

    assign den[t] = (al == '0) ? PW'(1) : PW'(al);
    assign num[t] = (al == '0) ? PW'(1) : PW'(sh_q[t]);

    always_comb begin
      has[t] = 1'b0;
      for (int s = 0; s < NS; s++)
        if (req_vld[s] && req_thr[s*TW +: TW] == TW'(t)) has[t] = 1'b1;
    end
  end

  logic          found;
  logic [TW-1:0] mx, mn;

  always_comb begin
    found = 1'b0;
    mx = '0;
    mn = '0;
    for (int t = 0; t < NT; t++) begin
      if (has[t]) begin
        if (!found) begin
          found = 1'b1;
          mx = TW'(t);
          mn = TW'(t);
        end else begin
          if (num[t] * den[mx] > num[mx] * den[t]) mx = TW'(t);
          if (num[t] * den[mn] < num[mn] * den[t]) mn = TW'(t);
        end
      end
    end
  end

  logic [PW-1:0] lhs, rhs;
  logic          over;
  assign lhs  = (num[mx] * den[mn]) << FB;
  assign rhs  = PW'(alpha_q8) * den[mx] * num[mn];
  assign over = (num[mx] == '0) ? (alpha_q8 <= ONE) : (lhs >= rhs);

  assign fair_mode = found && over;
  assign lag_thr   = mx;

  logic [KW-1:0] key, bkey;
  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    bkey = '0;
    key = '0;
    for (int s = 0; s < NS; s++) begin
      key = {fair_mode && (req_thr[s*TW +: TW] == mx), req_hit[s], req_age[s*AW +: AW]};
      if (req_vld[s] && (!pick_vld || key > bkey)) begin
        pick_vld = 1'b1;
        pick_idx = SW'(s);
        bkey = key;
      end
    end
  end
endmodule

// File: rtl/sfair_pick_chk.sv
module sfair_pick_chk #(
  parameter int NT = 4,
  parameter int NS = 16,
  parameter int AW = 6,
  parameter int RW = 16,
  parameter int TW = 2,
  parameter int SW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [RW-1:0]    alpha_q8,
  input logic [NS-1:0]    req_vld,
  input logic [NS*TW-1:0] req_thr,
  input logic [NS-1:0]    req_hit,
  input logic             pick_vld,
  input logic [SW-1:0]    pick_idx,
  input logic             fair_mode,
  input logic [TW-1:0]    lag_thr
);
  logic has_lag, any_hit;
  always_comb begin
    has_lag = 1'b0;
    any_hit = 1'b0;
    for (int s = 0; s < NS; s++) begin
      if (req_vld[s] && req_thr[s*TW +: TW] == lag_thr) has_lag = 1'b1;
      if (req_vld[s] && req_hit[s]) any_hit = 1'b1;
    end
  end

  a_r8_pick_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld |-> req_vld[pick_idx]);
  a_r8_pick_when_any: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld != '0) |-> pick_vld);
  a_r4_idle_not_fair: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld == '0) |-> !fair_mode);
  a_r4_zero_alpha_fair: assert property (@(posedge clk) disable iff (!rst_n)
    (alpha_q8 == '0 && req_vld != '0) |-> fair_mode);
  a_r5_lag_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld != '0) |-> has_lag);
  a_r7_fair_picks_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (fair_mode && pick_vld) |-> req_thr[pick_idx*TW +: TW] == lag_thr);
  a_r6_hit_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!fair_mode && any_hit) |-> req_hit[pick_idx]);
endmodule

bind sfair_pick sfair_pick_chk #(.NT(NT), .NS(NS), .AW(AW), .RW(RW), .TW(TW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alpha_q8(alpha_q8), .req_vld(req_vld), .req_thr(req_thr),
  .req_hit(req_hit), .pick_vld(pick_vld), .pick_idx(pick_idx), .fair_mode(fair_mode),
  .lag_thr(lag_thr));

// File: tb/sfair_pick_tb_top.sv
module sfair_pick_tb_top;
  localparam int NT = 4, NS = 16, CW = 10, AW = 6, RW = 16, TW = 2, SW = 4;
  localparam int SMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [RW-1:0] alpha = 16'd256;
  logic [NT-1:0] stall = '0;
  logic [CW-1:0] al [NT];
  logic rv [NS], rh [NS];
  logic [TW-1:0] rt [NS];
  logic [AW-1:0] ra [NS];

  logic [NT*CW-1:0] alone_w;
  logic [NS-1:0] vld_w, hit_w;
  logic [NS*TW-1:0] thr_w;
  logic [NS*AW-1:0] age_w;
  for (genvar t = 0; t < NT; t++) begin : g_a
    assign alone_w[t*CW +: CW] = al[t];
  end
  for (genvar s = 0; s < NS; s++) begin : g_r
    assign vld_w[s] = rv[s];
    assign hit_w[s] = rh[s];
    assign thr_w[s*TW +: TW] = rt[s];
    assign age_w[s*AW +: AW] = ra[s];
  end

  logic pick_vld, fair_mode;
  logic [SW-1:0] pick_idx;
  logic [TW-1:0] lag_thr;

  sfair_pick #(.NT(NT), .NS(NS), .CW(CW), .AW(AW), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .alpha_q8(alpha), .stall_in(stall), .alone_in(alone_w),
    .req_vld(vld_w), .req_thr(thr_w), .req_hit(hit_w), .req_age(age_w),
    .pick_vld(pick_vld), .pick_idx(pick_idx), .fair_mode(fair_mode), .lag_thr(lag_thr));

  int sh_m [NT];
  always @(posedge clk) begin
    for (int t = 0; t < NT; t++)
      if (!rst_n) sh_m[t] <= 0;
      else if (stall[t] && sh_m[t] < SMAX) sh_m[t] <= sh_m[t] + 1;
  end

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic model(output bit ev, output int ei, output bit ef, output int el);
    longint unsigned n [NT], d [NT];
    bit has [NT];
    bit found;
    int mx, mn, bk, k;
    found = 0; mx = 0; mn = 0;
    for (int t = 0; t < NT; t++) begin
      d[t] = (al[t] == 0) ? 1 : al[t];
      n[t] = (al[t] == 0) ? 1 : sh_m[t];
      has[t] = 0;
      for (int s = 0; s < NS; s++) if (rv[s] && rt[s] == t) has[t] = 1;
    end
    for (int t = 0; t < NT; t++)
      if (has[t]) begin
        if (!found) begin found = 1; mx = t; mn = t; end
        else begin
          if (n[t]*d[mx] > n[mx]*d[t]) mx = t;
          if (n[t]*d[mn] < n[mn]*d[t]) mn = t;
        end
      end
    if (!found) ef = 0;
    else if (n[mx] == 0) ef = (alpha <= 256);
    else ef = (n[mx]*d[mn]*256) >= (longint'(alpha)*d[mx]*n[mn]);
    el = mx;
    ev = 0; ei = 0; bk = -1;
    for (int s = 0; s < NS; s++) begin
      k = ((ef && rt[s] == mx) ? (1 << (AW+1)) : 0) + (rh[s] << AW) + ra[s];
      if (rv[s] && k > bk) begin ev = 1; ei = s; bk = k; end
    end
  endtask

  task automatic chk(string req);
    bit ev, ef; int ei, el;
    model(ev, ei, ef, el);
    checks++;
    if (pick_vld !== ev || fair_mode !== ef || lag_thr !== TW'(el) || (ev && pick_idx !== SW'(ei))) begin
      errors++;
      $display("FAIL %s: got vld=%0b idx=%0d fair=%0b lag=%0d exp vld=%0b idx=%0d fair=%0b lag=%0d",
               req, pick_vld, pick_idx, fair_mode, lag_thr, ev, ei, ef, el);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_req();
    for (int s = 0; s < NS; s++) begin rv[s] = 0; rh[s] = 0; rt[s] = 0; ra[s] = 0; end
  endtask

  task automatic setr(int s, int t, bit h, int a);
    rv[s] = 1; rt[s] = TW'(t); rh[s] = h; ra[s] = AW'(a);
  endtask

  initial begin
    void'($urandom(32'd4471));
    clr_req();
    for (int t = 0; t < NT; t++) al[t] = 10;
    step(3); rst_n = 1'b1;
    step(1); #1 chk("R8 reset idle");
    if (pick_vld !== 1'b0 || fair_mode !== 1'b0) begin errors++; $display("FAIL R4 idle: vld=%0b fair=%0b exp 0 0", pick_vld, fair_mode); end
    setr(3, 1, 0, 5); setr(7, 2, 1, 1); setr(9, 0, 1, 1);
    alpha = 16'd257; #1 chk("R3 all-zero slowdown, R6 hit then slot");
    alpha = 16'd256; #1 chk("R5 tie lowest id, R7 fair order");
    stall = 4'b1111; step(10);
    stall = 4'b0100; step(30);
    stall = 4'b0000; step(1);
    rh[7] = 0; ra[7] = 0;
    alpha = 16'd512;  #1 chk("R7 lag thread first");
    alpha = 16'd1024; #1 chk("R4 unfairness equal to alpha");
    alpha = 16'd1025; #1 chk("R4 just below alpha, R6");
    rv[7] = 0; alpha = 16'd512; #1 chk("R3 thread without request excluded");
    al[1] = 0; al[0] = 20; #1 chk("R2 zero estimate as 1.0");
    al[0] = 10; alpha = 16'd256; #1 chk("R5 equal slowdown tie");
    stall = 4'b0001; step(1100); stall = 4'b0000; step(1);
    al[0] = 10'd1023; alpha = 16'd257; #1 chk("R1 saturation hold");
    alpha = 16'd256; #1 chk("R1 saturated ratio 1.0");
    for (int i = 0; i < 3000; i++) begin
      stall = NT'($urandom);
      for (int t = 0; t < NT; t++) al[t] = ($urandom % 8 == 0) ? '0 : CW'(1 + $urandom % 300);
      alpha = ($urandom % 4 == 0) ? RW'(256 + $urandom % 8) : RW'($urandom % 2048);
      for (int s = 0; s < NS; s++) begin
        rv[s] = ($urandom % 3 == 0); rt[s] = TW'($urandom); rh[s] = $urandom; ra[s] = AW'($urandom);
      end
      #1 chk("R1-random R2 R3 R4 R5 R6 R7 R8");
      step(1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule